// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block sits between a memory controller and a row of memory devices. It takes a bus of command and address bits, plus clock-enable, termination and two active-low chip-select controls. On each rising clock edge it registers them and drives them out one cycle later. An even-parity bit arrives with the command bits. The buffer checks it and reports a mismatch on an active-low error flag. Once the flag falls, it stays low for a fixed two-cycle window. The select, clock-enable and termination controls take no part in the parity computation.

The block has a low-power gate. When both chip-selects are high, the command outputs and the parity output are frozen, and that cycle is neither captured nor checked. Two copies can be chained to cover a wider bus. The first copy runs in cascade mode (`cascade_first` high). Its `par_out` carries the parity of its own bits folded with the incoming parity bit, and its error flag is held inactive. That output feeds `par_in` of the second copy, which runs in standalone mode. The complete result then appears only on the second copy's flag.

The error flag is driven by a three-state machine: `ERR_IDLE` (flag high), `ERR_HOLD1` (first low cycle) and `ERR_HOLD2` (second low cycle). The transitions are:
- `ERR_IDLE` moves to `ERR_HOLD1` when a detection arrives.
- `ERR_HOLD1` moves to `ERR_HOLD2` when no detection arrives.
- `ERR_HOLD2` returns to `ERR_IDLE` when no detection arrives.
- A detection in either hold state restarts the window in `ERR_HOLD1`.

The active-low reset is asynchronous and overrides everything.

Top module: `cmdbuf_parity_reg`

## Requirements
- R1: While `rst_n` is low, without waiting for a clock, `q_data`, `q_cs0_n`, `q_cs1_n`, `q_cke`, `q_odt` and `par_out` are 0 and `err_n` is 1.
- R2: When `cs0_n` or `cs1_n` is low at a rising edge, `q_data` equals the `d_in` sampled at that edge. `q_cs0_n`, `q_cs1_n`, `q_cke` and `q_odt` always follow their inputs one edge later, whether or not the block is gated.
- R3: When `cs0_n` and `cs1_n` are both high at an edge, `q_data` and `par_out` keep their previous values.
- R4: On every capture, `par_out` becomes the XOR of all `d_in` bits and `par_in`. It is 0 when the data bits plus the parity bit hold an even number of ones. The select, clock-enable and termination inputs do not affect it.
- R5: In standalone mode (`cascade_first` = 0), a capture with `par_out` = 1 at edge k drives `err_n` low after edge k+2. It stays low through edge k+3 and returns high after edge k+4, provided no further bad capture follows.
- R6: A bad capture at edge k+1 directly after the one at edge k restarts the window, so `err_n` stays low after edges k+2, k+3 and k+4 and goes high after edge k+5.
- R7: A gated cycle (both selects high) captures nothing and raises no error, even when its data and parity bit disagree.
- R8: With `cascade_first` = 1, `err_n` stays high whatever the parity, while `par_out` still carries the partial parity of R4.
- R9: When two copies are chained first to second, the second copy's `err_n` goes low exactly when the bits of both copies and the original parity bit together hold an odd count of ones.
- R10: Asserting `rst_n` while `err_n` is low ends the pulse immediately.
- R11: After reset is released with all inputs low, every output keeps its reset value on the following edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cascade_first | input | 1 | 1: first device of a chain, error flag held high |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cke_in | input | 1 | Clock-enable control, not parity checked |
| odt_in | input | 1 | Termination control, not parity checked |
| d_in | input | DATA_W | Command and address bits |
| par_in | input | 1 | Even parity bit for `d_in` |
| q_data | output | DATA_W | Registered command and address bits |
| q_cs0_n | output | 1 | Registered chip select 0 |
| q_cs1_n | output | 1 | Registered chip select 1 |
| q_cke | output | 1 | Registered clock enable |
| q_odt | output | 1 | Registered termination control |
| par_out | output | 1 | Partial parity of the last capture |
| err_n | output | 1 | Parity error flag, active low |

## Verification
The embedded properties check the following on every cycle:
- A gated edge leaves `q_data` and `par_out` unchanged.
- An open edge delivers the sampled bits and their folded parity one edge later.
- A detection only ever follows a real capture.
- A falling error flag stays low for at least one more edge.
- Cascade mode keeps the flag high.
- The error state machine stays within its three encodings.

Some behaviours are shown only by the bench's scenarios:
- the exact edge at which the pulse starts and ends;
- the extension when two bad captures come back to back;
- the combined result of two chained copies;
- the asynchronous clearing of an active pulse;
- the quiet exit from reset.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    typedef enum logic [1:0] {
        ERR_IDLE  = 2'd0,
        ERR_HOLD1 = 2'd1,
        ERR_HOLD2 = 2'd2
    } err_state_e;

    typedef struct packed {
        logic cs0_n;
        logic cs1_n;
        logic cke;
        logic odt;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{cs0_n: 1'b0, cs1_n: 1'b0, cke: 1'b0, odt: 1'b0};

endpackage

// File: rtl/cmdbuf_capture.sv
module cmdbuf_capture
    import cmdbuf_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] d_in,
    input  ctl_t              ctl_in,
    input  logic              par_in,
    output logic [DATA_W-1:0] q_data,
    output ctl_t              ctl_q,
    output logic              par_q,
    output logic              cap_vld
);

    logic cap_en;
    logic par_fold;

    // Gate: capture whenever at least one select is asserted (low).
    assign cap_en   = ~(ctl_in.cs0_n & ctl_in.cs1_n);
    assign par_fold = (^d_in) ^ par_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_data  <= '0;
            ctl_q   <= CTL_RESET;
            par_q   <= 1'b0;
            cap_vld <= 1'b0;
        end else begin
            ctl_q   <= ctl_in;
            cap_vld <= cap_en;
            if (cap_en) begin
                q_data <= d_in;
                par_q  <= par_fold;
            end
        end
    end

    // R3: gated edge freezes data and parity output
    p_hold_when_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_in.cs0_n && ctl_in.cs1_n) |=> ($stable(q_data) && $stable(par_q)));

    // R2: open edge delivers the sampled bits one edge later
    p_capture_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctl_in.cs0_n && ctl_in.cs1_n)) |=> (q_data == $past(d_in)));

    // R4: partial parity folds the sampled bits and the parity input
    p_partial_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctl_in.cs0_n && ctl_in.cs1_n)) |=> (par_q == ((^$past(d_in)) ^ $past(par_in))));

endmodule

// File: rtl/cmdbuf_detect.sv
module cmdbuf_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_vld,
    input  logic par_q,
    input  logic first_dev,
    output logic err_det
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_det <= 1'b0;
        end else begin
            err_det <= cap_vld & par_q & ~first_dev;
        end
    end

    // R7: a detection only follows a real capture
    p_det_after_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_det |-> $past(cap_vld));

endmodule

// File: rtl/cmdbuf_err_fsm.sv
module cmdbuf_err_fsm
    import cmdbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_det,
    input  logic first_dev,
    output logic err_n
);

    err_state_e st_q;
    err_state_e st_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ERR_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Transitions
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ERR_IDLE:  st_nxt = err_det ? ERR_HOLD1 : ERR_IDLE;
            ERR_HOLD1: st_nxt = err_det ? ERR_HOLD1 : ERR_HOLD2;
            ERR_HOLD2: st_nxt = err_det ? ERR_HOLD1 : ERR_IDLE;
            default:   st_nxt = ERR_IDLE;
        endcase
    end

    // Registered output, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_n <= 1'b1;
        end else begin
            err_n <= first_dev | (st_nxt == ERR_IDLE);
        end
    end

    // R5: a falling flag is held for at least one more edge
    p_pulse_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(err_n) && !first_dev) |=> (!err_n || first_dev));

    // R5: state stays within its legal encodings
    p_state_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ERR_IDLE) || (st_q == ERR_HOLD1) || (st_q == ERR_HOLD2));

    // R8: cascade-first mode keeps the flag inactive
    p_first_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(first_dev) |-> err_n);

endmodule

// File: rtl/cmdbuf_parity_reg.sv
module cmdbuf_parity_reg
    import cmdbuf_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cascade_first,
    input  logic              cs0_n,
    input  logic              cs1_n,
    input  logic              cke_in,
    input  logic              odt_in,
    input  logic [DATA_W-1:0] d_in,
    input  logic              par_in,
    output logic [DATA_W-1:0] q_data,
    output logic              q_cs0_n,
    output logic              q_cs1_n,
    output logic              q_cke,
    output logic              q_odt,
    output logic              par_out,
    output logic              err_n
);

    ctl_t ctl_in;
    ctl_t ctl_q;
    logic cap_vld;
    logic err_det;

    assign ctl_in = '{cs0_n: cs0_n, cs1_n: cs1_n, cke: cke_in, odt: odt_in};

    cmdbuf_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_in    (d_in),
        .ctl_in  (ctl_in),
        .par_in  (par_in),
        .q_data  (q_data),
        .ctl_q   (ctl_q),
        .par_q   (par_out),
        .cap_vld (cap_vld)
    );

    cmdbuf_detect u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_vld   (cap_vld),
        .par_q     (par_out),
        .first_dev (cascade_first),
        .err_det   (err_det)
    );

    cmdbuf_err_fsm u_err_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_det   (err_det),
        .first_dev (cascade_first),
        .err_n     (err_n)
    );

    assign q_cs0_n = ctl_q.cs0_n;
    assign q_cs1_n = ctl_q.cs1_n;
    assign q_cke   = ctl_q.cke;
    assign q_odt   = ctl_q.odt;

    // R2: control outputs register every edge, gated or not
    p_ctl_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_cke == $past(cke_in) && q_odt == $past(odt_in)));

endmodule

// File: tb/cmdbuf_parity_reg_tb_top.sv
module cmdbuf_parity_reg_tb_top;

    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode1 = 1'b0;
    logic         cs0_n = 1'b0, cs1_n = 1'b0, cke = 1'b0, odt = 1'b0;
    logic [W-1:0] d1 = '0, d2 = '0;
    logic         p1 = 1'b0;

    logic [W-1:0] q1, q2;
    logic         qcs0_1, qcs1_1, qcke_1, qodt_1, po1, err1;
    logic         qcs0_2, qcs1_2, qcke_2, qodt_2, po2, err2;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cmdbuf_parity_reg #(.DATA_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cascade_first(mode1),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .cke_in(cke), .odt_in(odt),
        .d_in(d1), .par_in(p1),
        .q_data(q1), .q_cs0_n(qcs0_1), .q_cs1_n(qcs1_1), .q_cke(qcke_1),
        .q_odt(qodt_1), .par_out(po1), .err_n(err1)
    );

    cmdbuf_parity_reg #(.DATA_W(W)) dut2_i (
        .clk(clk), .rst_n(rst_n), .cascade_first(1'b0),
        .cs0_n(cs0_n), .cs1_n(cs1_n), .cke_in(cke), .odt_in(odt),
        .d_in(d2), .par_in(po1),
        .q_data(q2), .q_cs0_n(qcs0_2), .q_cs1_n(qcs1_2), .q_cke(qcke_2),
        .q_odt(qodt_2), .par_out(po2), .err_n(err2)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic fold(input logic [W-1:0] d, input logic p);
        return (^d) ^ p;
    endfunction

    task automatic drive(input logic [W-1:0] d, input logic p);
        d1 = d;
        p1 = p;
    endtask

    task automatic t_reset_entry();
        #4;
        chk("R1 q_data in reset", 32'(q1), 0);
        chk("R1 par_out in reset", 32'(po1), 0);
        chk("R1 ctl outputs in reset", {28'd0, qcs0_1, qcs1_1, qcke_1, qodt_1}, 0);
        chk("R1 err_n in reset", 32'(err1), 1);
        #7 rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R11 q_data after exit", 32'(q1), 0);
            chk("R11 err_n after exit", 32'(err1), 1);
        end
    endtask

    task automatic t_capture();
        logic [W-1:0] pats [3] = '{14'h1A5C, 14'h0F0F, 14'h3FFF};
        for (int i = 0; i < 3; i++) begin
            cs0_n = (i == 1); cs1_n = (i != 1);
            cke = i[0]; odt = ~i[0];
            drive(pats[i], ^pats[i]);
            tick();
            chk("R2 q_data capture", 32'(q1), 32'(pats[i]));
            chk("R2 q_cke follow", 32'(qcke_1), 32'(i[0]));
            chk("R4 even parity gives 0", 32'(po1), 0);
        end
        cs0_n = 1'b0; cs1_n = 1'b1;
        drive(14'h0003, 1'b1);
        tick();
        chk("R4 odd parity gives 1", 32'(po1), 32'(fold(14'h0003, 1'b1)));
        drive('0, 1'b0);
        tick(); tick(); tick(); tick();
    endtask

    task automatic t_error_pulse();
        drive(14'h0001, 1'b0);
        tick();
        drive('0, 1'b0);
        chk("R4 par_out flags mismatch", 32'(po1), 1);
        tick(); chk("R5 err_n high at k+1", 32'(err1), 1);
        tick(); chk("R5 err_n low at k+2", 32'(err1), 0);
        tick(); chk("R5 err_n low at k+3", 32'(err1), 0);
        tick(); chk("R5 err_n high at k+4", 32'(err1), 1);
        tick(); chk("R5 err_n stays high", 32'(err1), 1);
    endtask

    task automatic t_back_to_back();
        drive(14'h0010, 1'b0);
        tick();
        drive(14'h0300, 1'b1);
        tick(); chk("R6 err_n high at k+1", 32'(err1), 1);
        drive('0, 1'b0);
        tick(); chk("R6 err_n low at k+2", 32'(err1), 0);
        tick(); chk("R6 err_n low at k+3", 32'(err1), 0);
        tick(); chk("R6 err_n low at k+4", 32'(err1), 0);
        tick(); chk("R6 err_n high at k+5", 32'(err1), 1);
    endtask

    task automatic t_gated();
        cs0_n = 1'b0; cs1_n = 1'b1;
        drive(14'h2222, 1'b0);
        tick();
        cs0_n = 1'b1; cs1_n = 1'b1; cke = 1'b1; odt = 1'b1;
        drive(14'h0001, 1'b0);
        tick();
        chk("R3 q_data frozen", 32'(q1), 32'h2222);
        chk("R3 par_out frozen", 32'(po1), 0);
        chk("R2 q_cke registers while gated", 32'(qcke_1), 1);
        chk("R2 q_cs1_n registers while gated", 32'(qcs1_1), 1);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R7 no error on gated bad parity", 32'(err1), 1);
        end
        chk("R3 q_data still frozen", 32'(q1), 32'h2222);
        cs0_n = 1'b0; cs1_n = 1'b1; cke = 1'b0; odt = 1'b0;
        drive('0, 1'b0);
        tick(); tick(); tick();
    endtask

    task automatic t_first_dev();
        mode1 = 1'b1;
        drive(14'h0040, 1'b0);
        tick();
        chk("R8 partial parity in cascade mode", 32'(po1), 1);
        drive('0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R8 err_n held high", 32'(err1), 1);
        end
        mode1 = 1'b0;
        tick(); tick();
    endtask

    task automatic t_cascade(input logic [W-1:0] da, input logic [W-1:0] db, input logic pa);
        logic bad;
        bad = (^da) ^ (^db) ^ pa;
        mode1 = 1'b1;
        d2 = '0;
        drive('0, 1'b0);
        tick(); tick(); tick();
        drive(da, pa);
        tick();
        drive('0, 1'b0);
        d2 = db;
        tick();
        d2 = '0;
        chk("R9 second device captures", 32'(q2), 32'(db));
        tick(); chk("R9 err2 high at k+2", 32'(err2), 1);
        tick(); chk("R9 err2 at k+3", 32'(err2), 32'(!bad));
        tick(); chk("R9 err2 at k+4", 32'(err2), 32'(!bad));
        tick(); chk("R9 err2 high at k+5", 32'(err2), 1);
        chk("R8 first device err_n high", 32'(err1), 1);
        mode1 = 1'b0;
        tick(); tick();
    endtask

    task automatic t_reset_mid();
        drive(14'h0800, 1'b0);
        tick();
        drive('0, 1'b0);
        tick(); tick();
        chk("R10 pulse active before reset", 32'(err1), 0);
        #1 rst_n = 1'b0;
        #1;
        chk("R10 err_n cleared without clock", 32'(err1), 1);
        chk("R1 q_data cleared without clock", 32'(q1), 0);
        tick();
        #1 rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R11 q_data stays low", 32'(q1), 0);
            chk("R11 par_out stays low", 32'(po1), 0);
            chk("R11 err_n stays high", 32'(err1), 1);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_entry();
        t_capture();
        t_error_pulse();
        t_back_to_back();
        t_gated();
        t_first_dev();
        t_cascade(14'h0001, 14'h0000, 1'b0);
        t_cascade(14'h0001, 14'h0100, 1'b0);
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule